// File: doc/BRIEF.md
# SPI Master Burst Shift Engine

This block is the bit-level core of an SPI master. A single control word selects clock polarity and phase, bit order, how the chip-select lines behave, and whether received bytes are kept. When the start bit of that word is written, the engine runs one burst. It fetches transmit bytes from a TX FIFO, drives them on the serial output and assembles the serial input into bytes for an RX FIFO. A clock divider outside the block supplies separate launch and sample strobes, and the engine steps through its half-bit phases on them.

Two counts are taken at the start of a burst: the total byte count and the transmit byte count. Only the first *transmit count* bytes come from the TX FIFO. The remaining bytes of the burst are clocked out as zero dummy bytes, so a read can follow a short command within the same burst. For write-only traffic, a discard option keeps the RX FIFO untouched. The end of every burst is marked by a one-cycle completion pulse.

Top module: `spi_burst_engine`

## Requirements
- R1: Control word fields are: bit 0 phase (CPHA), bit 1 idle clock level (CPOL), bit 2 chip-select polarity (1 = lines idle high, active low), bits 5:4 chip-select index, bit 6 manual chip-select enable, bit 7 manual level, bit 8 discard receive, bit 12 LSB first, bit 31 start. `ctrl_rdata` returns the stored fields at those positions. A control write made while a burst is active is ignored.
- R2: A write with bit 31 set while idle starts a burst of `total_cnt` bytes (24-bit count). Bit 31 of `ctrl_rdata` and `busy` read 1 from the cycle after that write until the burst has finished, and then read 0.
- R3: Only the first `tx_cnt` bytes of a burst are popped from the TX FIFO (`tx_pop` is asserted only with `tx_valid`). Every later byte of the burst is sent as 0x00.
- R4: When the discard bit is set, `rx_push` never asserts.
- R5: If discard is clear and `rx_full` is high when a byte completes, that byte is dropped and `rx_ovf` pulses for one cycle in place of `rx_push`.
- R6: While idle, `sck` equals the CPOL bit. With CPHA=0 the input is sampled on the leading (first) clock edge of each bit and the output changes on the trailing edge. With CPHA=1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R7: With bit 12 clear, each byte is shifted out MSB first; with bit 12 set, LSB first.
- R8: With manual mode off, the indexed chip-select line sits at its active level while `busy` is high, and every other line sits at its inactive level.
- R9: With manual mode on, the indexed line is driven to the manual level bit and the other lines to the inactive level, whether or not a burst is active.
- R10: `done` pulses for exactly one cycle at the end of a burst, in the last cycle in which `busy` is high. A total count of 0 gives that pulse one cycle after the start write, with no `sck` edge.
- R11: If a byte still due from the TX FIFO is not yet available, `sck` stays at its idle level until the byte arrives. Then the burst continues.
- R12: Each received byte is assembled in the same bit order as transmission and presented on `rx_data` with a one-cycle `rx_push`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write value |
| ctrl_rdata | output | 32 | Stored control fields; bit 31 is the active flag |
| total_cnt | input | CNT_W | Bytes in the burst, sampled at start |
| tx_cnt | input | CNT_W | Bytes taken from the TX FIFO, sampled at start |
| launch_stb | input | 1 | Divider strobe for output-change half-bits |
| sample_stb | input | 1 | Divider strobe for input-sample half-bits |
| tx_valid | input | 1 | TX FIFO holds a byte |
| tx_data | input | WORD_W | TX FIFO head byte |
| tx_pop | output | 1 | Consume the TX FIFO head byte |
| rx_full | input | 1 | RX FIFO cannot accept a byte |
| rx_push | output | 1 | Write `rx_data` into the RX FIFO |
| rx_data | output | WORD_W | Received byte |
| rx_ovf | output | 1 | A received byte was dropped because the RX FIFO was full |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs | output | NUM_CS | Chip-select lines |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The bench builds the engine with its default parameters: 24-bit counts, four chip-select lines and 8-bit words. With these values every code of the two-bit chip-select index maps to a real line, so the single-active-line check covers the whole index field. Bursts are kept to a few bytes, which is enough to reach the boundaries that matter: a zero total, a transmit count below the total, and a TX FIFO that runs dry partway through a burst. Serial data is looped back, plain or inverted, and an independent edge monitor decodes the wire from the polarity and phase set in each test.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_FIN   = 2'd3
  } seq_st_e;

  // Stored configuration, decoded from the control word
  typedef struct packed {
    logic       lsb_first;
    logic       discard;
    logic       man_lvl;
    logic       man_en;
    logic [1:0] cs_idx;
    logic       cs_pol;
    logic       cpol;
    logic       cpha;
  } xfer_cfg_t;

  localparam int unsigned BIT_CPHA  = 0;
  localparam int unsigned BIT_CPOL  = 1;
  localparam int unsigned BIT_CSPOL = 2;
  localparam int unsigned BIT_CSLO  = 4;
  localparam int unsigned BIT_MANEN = 6;
  localparam int unsigned BIT_MANLV = 7;
  localparam int unsigned BIT_DISC  = 8;
  localparam int unsigned BIT_LSB   = 12;
  localparam int unsigned BIT_GO    = 31;

  function automatic xfer_cfg_t cfg_decode(input logic [31:0] w);
    xfer_cfg_t c;
    c.cpha      = w[BIT_CPHA];
    c.cpol      = w[BIT_CPOL];
    c.cs_pol    = w[BIT_CSPOL];
    c.cs_idx    = w[BIT_CSLO +: 2];
    c.man_en    = w[BIT_MANEN];
    c.man_lvl   = w[BIT_MANLV];
    c.discard   = w[BIT_DISC];
    c.lsb_first = w[BIT_LSB];
    return c;
  endfunction

  function automatic logic [31:0] cfg_encode(input xfer_cfg_t c, input logic active);
    logic [31:0] w;
    w                 = '0;
    w[BIT_CPHA]       = c.cpha;
    w[BIT_CPOL]       = c.cpol;
    w[BIT_CSPOL]      = c.cs_pol;
    w[BIT_CSLO +: 2]  = c.cs_idx;
    w[BIT_MANEN]      = c.man_en;
    w[BIT_MANLV]      = c.man_lvl;
    w[BIT_DISC]       = c.discard;
    w[BIT_LSB]        = c.lsb_first;
    w[BIT_GO]         = active;
    return w;
  endfunction

endpackage

// File: rtl/spi_burst_seq.sv
// Burst sequencer: configuration register, byte counters, FIFO handshakes.
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  input  logic [CNT_W-1:0]  total_cnt,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  input  logic              byte_end,
  input  logic [WORD_W-1:0] rx_word,
  output logic              ld,
  output logic [WORD_W-1:0] ld_data,
  output logic              shifting,
  output logic              busy,
  output logic              done,
  output xfer_cfg_t         cfg,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ovf
);

  seq_st_e           st_q, st_d;
  xfer_cfg_t         cfg_q, cfg_d;
  logic [CNT_W-1:0]  tot_q, tot_d;
  logic [CNT_W-1:0]  txn_q, txn_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  idx_inc;
  logic [WORD_W-1:0] rxd_q, rxd_d;
  logic              push_q, push_d;
  logic              ovf_q, ovf_d;
  logic              real_tx;
  logic              wr_ok;

  assign idx_inc = idx_q + CNT_W'(1);
  assign real_tx = (idx_q < txn_q);
  assign wr_ok   = ctrl_we && (st_q == ST_IDLE);

  always_comb begin
    st_d    = st_q;
    cfg_d   = cfg_q;
    tot_d   = tot_q;
    txn_d   = txn_q;
    idx_d   = idx_q;
    rxd_d   = rxd_q;
    push_d  = 1'b0;
    ovf_d   = 1'b0;
    ld      = 1'b0;
    ld_data = '0;
    tx_pop  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_ok) begin
          cfg_d = cfg_decode(ctrl_wdata);
          if (ctrl_wdata[BIT_GO]) begin
            tot_d = total_cnt;
            txn_d = tx_cnt;
            idx_d = '0;
            st_d  = (total_cnt == '0) ? ST_FIN : ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (!real_tx || tx_valid) begin
          ld      = 1'b1;
          tx_pop  = real_tx;
          ld_data = real_tx ? tx_data : '0;
          st_d    = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (byte_end) begin
          idx_d  = idx_inc;
          rxd_d  = rx_word;
          push_d = !cfg_q.discard && !rx_full;
          ovf_d  = !cfg_q.discard && rx_full;
          st_d   = (idx_inc == tot_q) ? ST_FIN : ST_LOAD;
        end
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      tot_q  <= '0;
      txn_q  <= '0;
      idx_q  <= '0;
      rxd_q  <= '0;
      push_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cfg_q  <= cfg_d;
      tot_q  <= tot_d;
      txn_q  <= txn_d;
      idx_q  <= idx_d;
      rxd_q  <= rxd_d;
      push_q <= push_d;
      ovf_q  <= ovf_d;
    end
  end

  assign shifting = (st_q == ST_SHIFT);
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);
  assign cfg      = cfg_q;
  assign rx_push  = push_q;
  assign rx_data  = rxd_q;
  assign rx_ovf   = ovf_q;

endmodule

// File: rtl/spi_burst_shift.sv
// Half-bit stepper: serial clock, output shift and input assembly for one byte.
module spi_burst_shift
  import spi_burst_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_data,
  input  xfer_cfg_t         cfg,
  input  logic              launch_stb,
  input  logic              sample_stb,
  input  logic              miso,
  output logic              byte_end,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);

  localparam int unsigned BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [WORD_W-1:0] rx_in;
  logic [BC_W-1:0]   bit_q, bit_d;
  logic              half_q, half_d;
  logic              act_q, act_d;
  logic              want_smp;
  logic              go;
  logic              do_shift;

  // first half samples for CPHA=0, second half samples for CPHA=1
  assign want_smp = (half_q == cfg.cpha);
  assign go       = active && (want_smp ? sample_stb : launch_stb);
  assign byte_end = go && half_q && (bit_q == LAST_BIT);
  assign rx_in    = cfg.lsb_first ? {miso, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], miso};
  assign rx_word  = want_smp ? rx_in : rx_q;
  assign do_shift = cfg.cpha ? (bit_q != '0) : (bit_q != LAST_BIT);

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    half_d = half_q;
    act_d  = act_q;
    if (ld) begin
      tx_d   = ld_data;
      bit_d  = '0;
      half_d = 1'b0;
      act_d  = 1'b0;
    end else if (go) begin
      act_d  = ~half_q;
      half_d = ~half_q;
      if (half_q) bit_d = bit_q + BC_W'(1);
      if (want_smp) begin
        rx_d = rx_in;
      end else if (do_shift) begin
        tx_d = cfg.lsb_first ? (tx_q >> 1) : (tx_q << 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      half_q <= half_d;
      act_q  <= act_d;
    end
  end

  assign sck  = cfg.cpol ^ act_q;
  assign mosi = cfg.lsb_first ? tx_q[0] : tx_q[WORD_W-1];

endmodule

// File: rtl/spi_burst_csel.sv
// Chip-select line drivers, one per line.
module spi_burst_csel
  import spi_burst_pkg::*;
#(
  parameter int unsigned NUM_CS = 4
) (
  input  xfer_cfg_t         cfg,
  input  logic              busy,
  output logic [NUM_CS-1:0] cs
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic sel;
    assign sel = (cfg.cs_idx == 2'(i));
    always_comb begin
      if (!sel)            cs[i] = cfg.cs_pol;
      else if (cfg.man_en) cs[i] = cfg.man_lvl;
      else                 cs[i] = busy ? ~cfg.cs_pol : cfg.cs_pol;
    end
  end

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned WORD_W = 8,
  parameter int unsigned NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  output logic [31:0]       ctrl_rdata,
  input  logic [CNT_W-1:0]  total_cnt,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic              launch_stb,
  input  logic              sample_stb,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_ovf,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs,
  output logic              busy,
  output logic              done
);

  xfer_cfg_t         cfg;
  logic              ld;
  logic [WORD_W-1:0] ld_data;
  logic              shifting;
  logic              byte_end;
  logic [WORD_W-1:0] rx_word;

  spi_burst_seq #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .total_cnt  (total_cnt),
    .tx_cnt     (tx_cnt),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_pop     (tx_pop),
    .rx_full    (rx_full),
    .byte_end   (byte_end),
    .rx_word    (rx_word),
    .ld         (ld),
    .ld_data    (ld_data),
    .shifting   (shifting),
    .busy       (busy),
    .done       (done),
    .cfg        (cfg),
    .rx_push    (rx_push),
    .rx_data    (rx_data),
    .rx_ovf     (rx_ovf)
  );

  spi_burst_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (shifting),
    .ld         (ld),
    .ld_data    (ld_data),
    .cfg        (cfg),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .miso       (miso),
    .byte_end   (byte_end),
    .rx_word    (rx_word),
    .sck        (sck),
    .mosi       (mosi)
  );

  spi_burst_csel #(.NUM_CS(NUM_CS)) u_csel (
    .cfg  (cfg),
    .busy (busy),
    .cs   (cs)
  );

  assign ctrl_rdata = cfg_encode(cfg, busy);

endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk #(
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              sck,
  input logic [31:0]       ctrl_rdata,
  input logic              rx_push,
  input logic              rx_ovf,
  input logic              tx_pop,
  input logic              tx_valid,
  input logic [NUM_CS-1:0] cs
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done)); // R10

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == ctrl_rdata[1])); // R6

  AST_DISCARD_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[8] |-> !rx_push); // R4

  AST_PUSH_OVF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_push && rx_ovf)); // R5

  AST_POP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid); // R3

  AST_AUTO_CS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctrl_rdata[6]) |-> ($countones(cs ^ {NUM_CS{ctrl_rdata[2]}}) == 1)); // R8

  AST_AUTO_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ctrl_rdata[6]) |-> (cs == {NUM_CS{ctrl_rdata[2]}})); // R8

endmodule

bind spi_burst_engine spi_burst_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .sck        (sck),
  .ctrl_rdata (ctrl_rdata),
  .rx_push    (rx_push),
  .rx_ovf     (rx_ovf),
  .tx_pop     (tx_pop),
  .tx_valid   (tx_valid),
  .cs         (cs)
);

// File: tb/spi_burst_engine_test.sv
`timescale 1ns/1ps
module spi_burst_engine_test;

  logic        clk;
  logic        rst_n;
  logic        ctrl_we;
  logic [31:0] ctrl_wdata;
  logic [31:0] ctrl_rdata;
  logic [23:0] total_cnt;
  logic [23:0] tx_cnt;
  logic        launch_stb;
  logic        sample_stb;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_pop;
  logic        rx_full;
  logic        rx_push;
  logic [7:0]  rx_data;
  logic        rx_ovf;
  logic        miso;
  logic        sck;
  logic        mosi;
  logic [3:0]  cs;
  logic        busy;
  logic        done;

  spi_burst_engine uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .total_cnt(total_cnt), .tx_cnt(tx_cnt),
    .launch_stb(launch_stb), .sample_stb(sample_stb), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
    .rx_data(rx_data), .rx_ovf(rx_ovf), .miso(miso), .sck(sck), .mosi(mosi),
    .cs(cs), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests;
  int n_fail;

  // TX FIFO model
  logic [7:0] tx_mem [16];
  int tx_wr, tx_rd;
  bit pop_pend;
  assign tx_valid = (tx_rd < tx_wr);
  assign tx_data  = tx_mem[tx_rd[3:0]];

  // serial loopback, optionally inverted
  bit inv_lb;
  assign miso = mosi ^ inv_lb;

  // divider model
  int div_cnt;
  always @(posedge clk) begin
    #5;
    div_cnt    = div_cnt + 1;
    sample_stb = ((div_cnt % 4) == 1);
    launch_stb = ((div_cnt % 4) == 3);
  end

  // monitors
  bit       m_cpol, m_cpha, m_cspol;
  logic     sck_prev;
  int       edge_n, bit_n, cap_n, rx_n, ovf_n, done_n, busy_n, pop_n;
  logic [7:0] mon_sh;
  logic [7:0] cap [16];
  logic [7:0] rx_got [16];
  logic [3:0] cs_seen;

  always @(negedge clk) begin
    if (pop_pend) begin tx_rd = tx_rd + 1; pop_pend = 0; end
    if (tx_pop) begin pop_pend = 1; pop_n = pop_n + 1; end
    if (rx_push) begin if (rx_n < 16) rx_got[rx_n] = rx_data; rx_n = rx_n + 1; end
    if (rx_ovf) ovf_n = ovf_n + 1;
    if (done) done_n = done_n + 1;
    if (busy) begin
      busy_n  = busy_n + 1;
      cs_seen = cs_seen | (cs ^ {4{m_cspol}});
    end
    if (sck !== sck_prev) begin
      edge_n = edge_n + 1;
      // leading edge leaves the idle level; sample edge is leading when CPHA=0
      if ((sck != m_cpol) == !m_cpha) begin
        mon_sh = {mon_sh[6:0], mosi};
        bit_n  = bit_n + 1;
        if (bit_n == 8) begin
          if (cap_n < 16) cap[cap_n] = mon_sh;
          cap_n = cap_n + 1;
          bit_n = 0;
        end
      end
      sck_prev = sck;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_tests = n_tests + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit cpha, input bit cpol, input bit cspol,
                                     input int idx, input bit man, input bit lvl,
                                     input bit disc, input bit lsb);
    logic [31:0] w;
    w = '0;
    w[0] = cpha; w[1] = cpol; w[2] = cspol; w[5:4] = 2'(idx);
    w[6] = man; w[7] = lvl; w[8] = disc; w[12] = lsb;
    return w;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic wr_ctrl(input logic [31:0] w);
    ctrl_we    = 1'b1;
    ctrl_wdata = w;
    step(1);
    ctrl_we    = 1'b0;
    ctrl_wdata = '0;
  endtask

  task automatic load_tx(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input int n);
    tx_mem[0] = b0; tx_mem[1] = b1; tx_mem[2] = b2;
    tx_rd = 0; tx_wr = n; pop_pend = 0;
  endtask

  task automatic setup(input logic [31:0] w);
    wr_ctrl(w);
    m_cpha = w[0]; m_cpol = w[1]; m_cspol = w[2];
    sck_prev = sck;
    edge_n = 0; bit_n = 0; cap_n = 0; rx_n = 0; ovf_n = 0;
    done_n = 0; busy_n = 0; pop_n = 0; cs_seen = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      if (done_n > 0) break;
      step(1);
    end
    step(2);
  endtask

  task automatic run(input logic [31:0] w, input int tot, input int txn);
    setup(w);
    total_cnt = 24'(tot);
    tx_cnt    = 24'(txn);
    wr_ctrl(w | 32'h8000_0000);
    wait_done();
  endtask

  task automatic t_reset();
    chk("R2 reset busy", busy, 0);
    chk("R1 reset rdata", ctrl_rdata, 0);
    chk("R6 reset sck", sck, 0);
    chk("R8 reset cs", cs, 0);
    chk("R10 reset done", done, 0);
  endtask

  task automatic t_mode0_msb();
    logic [31:0] w;
    w = mk(0, 0, 1, 2, 0, 0, 0, 0);
    load_tx(8'hA5, 8'h3C, 8'h81, 3);
    inv_lb = 0;
    run(w, 3, 3);
    chk("R2 three bytes clocked", edge_n, 48);
    chk("R7 msb byte0", cap[0], 8'hA5);
    chk("R7 msb byte2", cap[2], 8'h81);
    chk("R12 rx count", rx_n, 3);
    chk("R12 rx byte1", rx_got[1], 8'h3C);
    chk("R10 one done", done_n, 1);
    chk("R8 only line 2 active", cs_seen, 4'b0100);
    chk("R8 idle high after", cs, 4'b1111);
    chk("R2 start bit cleared", ctrl_rdata[31], 0);
    chk("R1 fields readback", ctrl_rdata, w);
  endtask

  task automatic t_mode3_lsb();
    logic [31:0] w;
    w = mk(1, 1, 0, 1, 0, 0, 0, 1);
    load_tx(8'h12, 8'hF0, 8'h00, 2);
    inv_lb = 1;
    run(w, 2, 2);
    inv_lb = 0;
    chk("R6 mode3 edges", edge_n, 32);
    chk("R6 idle high", sck, 1);
    chk("R7 lsb byte0", cap[0], rev8(8'h12));
    chk("R7 lsb byte1", cap[1], rev8(8'hF0));
    chk("R12 lsb rx byte0", rx_got[0], 8'hED);
    chk("R12 lsb rx byte1", rx_got[1], 8'h0F);
    chk("R8 only line 1 active", cs_seen, 4'b0010);
  endtask

  task automatic t_mode1_msb();
    logic [31:0] w;
    w = mk(1, 0, 1, 0, 0, 0, 0, 0);
    load_tx(8'h6B, 8'h00, 8'h00, 1);
    run(w, 1, 1);
    chk("R6 mode1 byte", cap[0], 8'h6B);
    chk("R12 mode1 rx", rx_got[0], 8'h6B);
  endtask

  task automatic t_dummy();
    load_tx(8'hC3, 8'h77, 8'h77, 3);
    run(mk(0, 0, 1, 0, 0, 0, 0, 0), 4, 1);
    chk("R3 one pop", pop_n, 1);
    chk("R3 real byte", cap[0], 8'hC3);
    chk("R3 dummy byte1", cap[1], 8'h00);
    chk("R3 dummy byte3", cap[3], 8'h00);
    chk("R3 four bytes", cap_n, 4);
    chk("R3 fifo left", tx_wr - tx_rd, 2);
  endtask

  task automatic t_discard();
    load_tx(8'h55, 8'hAA, 8'h00, 2);
    run(mk(0, 0, 1, 3, 0, 0, 1, 0), 2, 2);
    chk("R4 no push", rx_n, 0);
    chk("R4 no ovf", ovf_n, 0);
    chk("R4 bytes still sent", cap[1], 8'hAA);
  endtask

  task automatic t_overflow();
    load_tx(8'h01, 8'h02, 8'h03, 3);
    rx_full = 1;
    run(mk(0, 0, 1, 0, 0, 0, 0, 0), 3, 3);
    rx_full = 0;
    chk("R5 ovf pulses", ovf_n, 3);
    chk("R5 no push", rx_n, 0);
  endtask

  task automatic t_zero();
    load_tx(8'h99, 8'h00, 8'h00, 1);
    run(mk(0, 1, 1, 0, 0, 0, 0, 0), 0, 1);
    chk("R10 zero done", done_n, 1);
    chk("R10 zero no edges", edge_n, 0);
    chk("R10 zero busy one cycle", busy_n, 1);
    chk("R10 zero no pop", pop_n, 0);
  endtask

  task automatic t_stall();
    load_tx(8'h4E, 8'hB1, 8'h00, 1);
    setup(mk(0, 0, 1, 0, 0, 0, 0, 0));
    total_cnt = 24'd2;
    tx_cnt    = 24'd2;
    wr_ctrl(32'h8000_0004);
    step(120);
    chk("R11 waiting busy", busy, 1);
    chk("R2 active bit", ctrl_rdata[31], 1);
    chk("R11 clock held", edge_n, 16);
    chk("R11 sck idle", sck, 0);
    tx_wr = 2;
    wait_done();
    chk("R11 resumed edges", edge_n, 32);
    chk("R11 second byte", cap[1], 8'hB1);
  endtask

  task automatic t_manual();
    wr_ctrl(mk(0, 0, 0, 3, 1, 1, 0, 0));
    step(1);
    chk("R9 level high", cs, 4'b1000);
    wr_ctrl(mk(0, 0, 0, 3, 1, 0, 0, 0));
    step(1);
    chk("R9 level low", cs, 4'b0000);
    wr_ctrl(mk(0, 0, 1, 3, 1, 0, 0, 0));
    step(1);
    chk("R9 inverted others", cs, 4'b0111);
    load_tx(8'h10, 8'h00, 8'h00, 1);
    run(mk(0, 0, 1, 3, 1, 0, 0, 0), 1, 1);
    chk("R9 held through burst", cs_seen, 4'b1000);
    chk("R9 after burst", cs, 4'b0111);
  endtask

  task automatic t_busy_write();
    logic [31:0] w;
    w = mk(0, 0, 1, 0, 0, 0, 0, 0);
    load_tx(8'hE7, 8'h18, 8'h00, 2);
    setup(w);
    total_cnt = 24'd2;
    tx_cnt    = 24'd2;
    wr_ctrl(w | 32'h8000_0000);
    step(10);
    wr_ctrl(mk(1, 1, 0, 2, 0, 0, 1, 1));
    wait_done();
    chk("R1 write ignored", ctrl_rdata, w);
    chk("R1 burst unaffected", cap[1], 8'h18);
    chk("R1 rx unaffected", rx_n, 2);
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0;
    total_cnt = '0; tx_cnt = '0; rx_full = 1'b0; inv_lb = 0;
    launch_stb = 1'b0; sample_stb = 1'b0; div_cnt = 0;
    tx_wr = 0; tx_rd = 0; pop_pend = 0;
    for (int i = 0; i < 16; i++) tx_mem[i] = '0;
    m_cpol = 0; m_cpha = 0; m_cspol = 0; sck_prev = 1'b0;
    edge_n = 0; bit_n = 0; cap_n = 0; rx_n = 0; ovf_n = 0;
    done_n = 0; busy_n = 0; pop_n = 0; cs_seen = '0; mon_sh = '0;
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_mode0_msb();
    t_mode3_lsb();
    t_mode1_msb();
    t_dummy();
    t_discard();
    t_overflow();
    t_zero();
    t_stall();
    t_manual();
    t_busy_write();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests = n_tests + 1;
    n_fail  = n_fail + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule